// File: doc/BRIEF.md
# Sleep-Tolerant Serial Peripheral Port

This block is an 8-bit full-duplex SPI port that can act as bus master or bus slave. A small register port lets the CPU configure it and move data. The block also has a sleep input, a wake output and an interrupt output, so it keeps working while the chip is in a low-power state.

In slave mode the shift logic is clocked only by the incoming serial clock. A whole byte can arrive while the system clock is stopped. When it completes, a toggle crosses into the system domain through a two-flop synchronizer. If interrupts are enabled, a wake request is raised straight away from the serial-clock domain, so the chip can restart its clock.

In master mode, raising `sleep_i` freezes the engine at its exact bit position. The divider, edge counter, shift registers and serial clock level all hold. When sleep is released, the engine finishes the remaining bits.

Top module: `spi_sleep_port`

Register map (`addr_i`):
- 0 is CTRL: bit0 enable, bit1 master, bit2 CPOL, bit3 CPHA, bit4 interrupt enable.
- 1 is STATUS: bit0 buffer full, bit1 done, bit2 overflow, bit3 write collision, bit4 busy. Writing 1 to bits 1..3 clears them.
- 2 is DATA: a read returns the receive buffer; a write loads the transmit byte.

## Requirements
- R1: After reset, CTRL and STATUS read 0, `sck_o`, `sdo_o`, `irq_o` and `wake_o` are 0.
- R2: In master mode with enable set, writing DATA while not busy sends the byte MSB first on `sdo_o` and takes a byte from `sdi_i`. The transfer uses 16 serial clock edges, with HALF_DIV system clocks per half period. The received byte goes to the buffer, and STATUS bits 0 and 1 are set.
- R3: CTRL bit2 sets the idle level of the serial clock. With CTRL bit3 at 0, data is sampled on the leading edge and changed on the trailing edge; with bit3 at 1, data is changed on the leading edge and sampled on the trailing edge. This holds in both master and slave modes.
- R4: In slave mode with `ss_ni` low, `sck_i` edges alone shift a full byte, with no system clock running. The byte and the done flag reach the CPU port once the system clock runs and the two-flop synchronizer has passed the completion.
- R5: When CTRL bit4 is set and a slave byte completes, `wake_o` rises without any system clock edge. It falls once the system domain has registered the completion.
- R6: When CTRL bit4 is clear, a completed slave byte never raises `wake_o`, but STATUS bit1 is still set once the clock runs.
- R7: In master mode, while `sleep_i` is high, `sck_o`, `sdo_o` and the busy state hold. After release, the remaining edges complete, giving 16 edges in total and correct data.
- R8: Reading DATA returns the receive buffer and clears STATUS bit0.
- R9: A byte that completes while STATUS bit0 is set sets STATUS bit2, and the buffer keeps its older byte.
- R10: Writing DATA while busy sets STATUS bit3, and the write is ignored; the transfer in progress is unchanged.
- R11: Clearing CTRL bit0 stops any transfer, clears busy, drives `sck_o` to the CPOL level and drives `sdo_o` to 0.
- R12: `irq_o` equals STATUS bit1 AND CTRL bit4, and writing 1 to a STATUS flag bit (1, 2 or 3) clears that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (may stop in sleep) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data (combinational) |
| sleep_i | input | 1 | Low-power state; freezes the master engine |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request from a slave byte completion |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| ss_ni | input | 1 | Slave select, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |

## Verification
The hardest case to reach is a slave byte that completes while the system clock is fully stopped. The bench gates its own clock generator and drives eight serial clock cycles by time delays alone. It then checks `wake_o` before any system edge occurs, and checks the flags and the buffer only after restarting the clock. The second hard case is a master transfer frozen mid-byte. The bench counts serial edges with a slave model and raises `sleep_i` after a few edges. It then checks that no edge, data change or busy change occurs for tens of cycles, and that the edge total is exactly 16 after release.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } reg_addr_e;

  localparam int unsigned CT_EN   = 0;
  localparam int unsigned CT_MST  = 1;
  localparam int unsigned CT_CPOL = 2;
  localparam int unsigned CT_CPHA = 3;
  localparam int unsigned CT_IE   = 4;

  localparam int unsigned ST_FULL = 0;
  localparam int unsigned ST_DONE = 1;
  localparam int unsigned ST_OVF  = 2;
  localparam int unsigned ST_WCOL = 3;
  localparam int unsigned ST_BUSY = 4;
endpackage

// File: rtl/spi_bit_sync.sv
module spi_bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/spi_slave_shift.sv
// Serial-clock-only slave shifter; DATA_W must be a power of two.
module spi_slave_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              rst_ni,
  input  logic              act_ni,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] tx_i,
  output logic              sdo_o,
  output logic              done_tgl_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sck_int;
  logic              sh_rst_n;
  logic [CNT_W-1:0]  smp_cnt_q, lch_cnt_q, out_idx;
  logic [DATA_W-2:0] sh_q;
  logic              tgl_q;
  logic [DATA_W-1:0] hold_q;

  // posedge of sck_int is always the sampling edge
  assign sck_int  = sck_i ^ cpol_i ^ cpha_i;
  assign sh_rst_n = act_ni & ~ss_ni;

  always_ff @(posedge sck_int or negedge sh_rst_n) begin
    if (!sh_rst_n) begin
      smp_cnt_q <= '0;
      sh_q      <= '0;
    end else begin
      smp_cnt_q <= smp_cnt_q + 1'b1;
      sh_q      <= {sh_q[DATA_W-3:0], sdi_i};
    end
  end

  always_ff @(posedge sck_int or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q  <= 1'b0;
      hold_q <= '0;
    end else if (sh_rst_n && smp_cnt_q == LAST) begin
      tgl_q  <= ~tgl_q;
      hold_q <= {sh_q, sdi_i};
    end
  end

  always_ff @(negedge sck_int or negedge sh_rst_n) begin
    if (!sh_rst_n) lch_cnt_q <= '0;
    else           lch_cnt_q <= lch_cnt_q + 1'b1;
  end

  // CPHA=1 spends its first launch edge presenting the MSB
  assign out_idx    = ~(lch_cnt_q - CNT_W'(cpha_i));
  assign sdo_o      = sh_rst_n & tx_i[out_idx];
  assign done_tgl_o = tgl_q;
  assign rx_o       = hold_q;
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ce_i,
  input  logic              start_i,
  input  logic              cpha_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] tx_i,
  output logic              busy_o,
  output logic              lvl_o,
  output logic              sdo_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned EC_W  = $clog2(EDGES);
  localparam int unsigned DIV_W = $clog2(HALF_DIV) + 1;
  localparam logic [EC_W-1:0]  LAST_EDGE = EC_W'(EDGES - 1);
  localparam logic [DIV_W-1:0] DIV_TOP   = DIV_W'(HALF_DIV - 1);

  logic              busy_q, lvl_q, done_q;
  logic [DIV_W-1:0]  div_q;
  logic [EC_W-1:0]   edge_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q, rx_q;
  logic              smp_edge, lch_edge;

  // even edge count = leading edge
  assign smp_edge = (edge_q[0] == cpha_i);
  assign lch_edge = !smp_edge && (edge_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      lvl_q   <= 1'b0;
      done_q  <= 1'b0;
      div_q   <= '0;
      edge_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (clr_i) begin
        busy_q <= 1'b0;
        lvl_q  <= 1'b0;
        div_q  <= '0;
        edge_q <= '0;
      end else if (ce_i) begin
        if (start_i && !busy_q) begin
          busy_q  <= 1'b1;
          tx_sh_q <= tx_i;
          div_q   <= '0;
          edge_q  <= '0;
          lvl_q   <= 1'b0;
        end else if (busy_q) begin
          if (div_q == DIV_TOP) begin
            div_q  <= '0;
            lvl_q  <= ~lvl_q;
            edge_q <= edge_q + 1'b1;
            if (smp_edge) rx_sh_q <= {rx_sh_q[DATA_W-2:0], sdi_i};
            if (lch_edge) tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
            if (edge_q == LAST_EDGE) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              rx_q   <= cpha_i ? {rx_sh_q[DATA_W-2:0], sdi_i} : rx_sh_q;
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign lvl_o  = lvl_q;
  assign sdo_o  = tx_sh_q[DATA_W-1];
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_sleep_port.sv
module spi_sleep_port
  import spi_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sleep_i,
  output logic              irq_o,
  output logic              wake_o,
  output logic              sck_o,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              sdi_i,
  output logic              sdo_o
);
  logic en_q, master_q, cpol_q, cpha_q, ie_q;
  logic full_q, done_q, ovf_q, wcol_q;
  logic [DATA_W-1:0] tx_q, rx_buf_q;

  logic wr_ctrl, wr_stat, wr_data, rd_data;
  logic busy, start, wcol_set, evt;
  logic [DATA_W-1:0] evt_byte;

  logic m_busy, m_lvl, m_sdo, m_done;
  logic [DATA_W-1:0] m_rx;

  logic slv_act_n, s_sdo, s_tgl, s_tgl_sync, s_seen_q, s_evt, ss_sync;
  logic [DATA_W-1:0] s_rx;

  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign wr_stat = wr_i && (addr_i == ADDR_STAT);
  assign wr_data = wr_i && (addr_i == ADDR_DATA);
  assign rd_data = rd_i && (addr_i == ADDR_DATA);

  assign busy     = en_q && (master_q ? m_busy : ~ss_sync);
  assign wcol_set = wr_data && busy;
  assign start    = wr_data && en_q && master_q && !busy && !sleep_i;

  spi_master_engine #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_mst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~en_q | ~master_q),
    .ce_i   (~sleep_i),
    .start_i(start),
    .cpha_i (cpha_q),
    .sdi_i  (sdi_i),
    .tx_i   (wdata_i),
    .busy_o (m_busy),
    .lvl_o  (m_lvl),
    .sdo_o  (m_sdo),
    .done_o (m_done),
    .rx_o   (m_rx)
  );

  assign slv_act_n = rst_ni & en_q & ~master_q;

  spi_slave_shift #(.DATA_W(DATA_W)) u_slv (
    .rst_ni    (rst_ni),
    .act_ni    (slv_act_n),
    .sck_i     (sck_i),
    .ss_ni     (ss_ni),
    .cpol_i    (cpol_q),
    .cpha_i    (cpha_q),
    .sdi_i     (sdi_i),
    .tx_i      (tx_q),
    .sdo_o     (s_sdo),
    .done_tgl_o(s_tgl),
    .rx_o      (s_rx)
  );

  spi_bit_sync #(.STAGES(2), .RST_VAL(1'b0)) u_tgl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (s_tgl),
    .q_o   (s_tgl_sync)
  );

  spi_bit_sync #(.STAGES(2), .RST_VAL(1'b1)) u_ss_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ss_ni),
    .q_o   (ss_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_seen_q <= 1'b0;
    else         s_seen_q <= s_tgl_sync;
  end

  assign s_evt    = s_tgl_sync ^ s_seen_q;
  assign evt      = m_done | s_evt;
  assign evt_byte = m_done ? m_rx : s_rx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      master_q <= 1'b0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      ie_q     <= 1'b0;
      full_q   <= 1'b0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
      wcol_q   <= 1'b0;
      tx_q     <= '0;
      rx_buf_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q     <= wdata_i[CT_EN];
        master_q <= wdata_i[CT_MST];
        cpol_q   <= wdata_i[CT_CPOL];
        cpha_q   <= wdata_i[CT_CPHA];
        ie_q     <= wdata_i[CT_IE];
      end
      if (wr_data && !wcol_set) tx_q <= wdata_i;
      if (evt && !full_q) begin
        full_q   <= 1'b1;
        rx_buf_q <= evt_byte;
      end else if (rd_data) begin
        full_q <= 1'b0;
      end
      done_q <= (done_q & ~(wr_stat & wdata_i[ST_DONE])) | evt;
      ovf_q  <= (ovf_q  & ~(wr_stat & wdata_i[ST_OVF]))  | (evt & full_q);
      wcol_q <= (wcol_q & ~(wr_stat & wdata_i[ST_WCOL])) | wcol_set;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: rdata_o = DATA_W'({ie_q, cpha_q, cpol_q, master_q, en_q});
      ADDR_STAT: rdata_o = DATA_W'({busy, wcol_q, ovf_q, done_q, full_q});
      ADDR_DATA: rdata_o = rx_buf_q;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o  = done_q & ie_q;
  // raised from the serial-clock domain; needs no system edge
  assign wake_o = ie_q & (s_tgl ^ s_seen_q);
  assign sck_o  = (en_q && master_q) ? (m_lvl ^ cpol_q) : cpol_q;
  assign sdo_o  = en_q & (master_q ? m_sdo : s_sdo);
endmodule

// File: rtl/spi_sleep_port_chk.sv
module spi_sleep_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sleep_i,
  input logic              en_i,
  input logic              master_i,
  input logic              cpol_i,
  input logic              sck_o,
  input logic              sdo_o,
  input logic              m_busy_i,
  input logic              m_done_i,
  input logic              evt_i,
  input logic              full_i,
  input logic              ovf_i,
  input logic              wcol_i,
  input logic              wr_data_i,
  input logic              rd_data_i,
  input logic              busy_i,
  input logic [DATA_W-1:0] rx_buf_i
);
  // R7
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && $past(sleep_i) && en_i && $past(en_i) && master_i && $past(master_i)
     && $stable(cpol_i)) |-> ($stable(sck_o) && $stable(sdo_o) && $stable(m_busy_i)));

  // R9
  ovf_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && full_i) |=> (ovf_i && $stable(rx_buf_i)));

  // R10
  wcol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data_i && busy_i) |=> wcol_i);

  // R8
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !evt_i) |=> !full_i);

  // R2
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_done_i |-> (!m_busy_i && $past(m_busy_i)));
endmodule

bind spi_sleep_port spi_sleep_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sleep_i  (sleep_i),
  .en_i     (en_q),
  .master_i (master_q),
  .cpol_i   (cpol_q),
  .sck_o    (sck_o),
  .sdo_o    (sdo_o),
  .m_busy_i (m_busy),
  .m_done_i (m_done),
  .evt_i    (evt),
  .full_i   (full_q),
  .ovf_i    (ovf_q),
  .wcol_i   (wcol_q),
  .wr_data_i(wr_data),
  .rd_data_i(rd_data),
  .busy_i   (busy),
  .rx_buf_i (rx_buf_q)
);

// File: tb/tb_spi_sleep_port.sv
module tb_spi_sleep_port;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sleep = 1'b0;
  logic       irq, wake, sck_o, sdo;
  logic       sck_i = 1'b0, ss_n = 1'b1, sdi = 1'b0;

  int n_chk = 0, n_bad = 0;

  always #5 clk = clk_run ? ~clk : 1'b0;

  spi_sleep_port #(.DATA_W(8), .HALF_DIV(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .sleep_i(sleep), .irq_o(irq),
    .wake_o(wake), .sck_o(sck_o), .sck_i(sck_i), .ss_ni(ss_n),
    .sdi_i(sdi), .sdo_o(sdo)
  );

  // slave model for master-mode tests (CPOL=0, CPHA=0)
  logic       mdl_on = 1'b0;
  logic [7:0] mdl_tx = 8'h00, mdl_cap = 8'h00;
  int         mdl_edges = 0, mdl_bit = 7;
  always @(posedge sck_o) if (mdl_on) mdl_cap = {mdl_cap[6:0], sdo};
  always @(negedge sck_o) if (mdl_on) begin
    mdl_bit--;
    if (mdl_bit >= 0) sdi = mdl_tx[mdl_bit];
  end
  always @(sck_o) if (mdl_on) mdl_edges++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk); addr = 2'd1; #1;
      if (!rdata[4]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic mdl_start(input logic [7:0] pat);
    mdl_tx = pat; mdl_bit = 7; sdi = pat[7]; mdl_edges = 0; mdl_cap = 8'h00; mdl_on = 1'b1;
  endtask

  task automatic slave_xfer(input logic [7:0] mosi, input logic pol, input logic pha,
                            output logic [7:0] miso);
    sck_i = pol; #20; ss_n = 1'b0; #20;
    for (int i = 7; i >= 0; i--) begin
      if (!pha) begin
        sdi = mosi[i]; #20; miso[i] = sdo; sck_i = ~pol; #20; sck_i = pol;
      end else begin
        sck_i = ~pol; sdi = mosi[i]; #20; miso[i] = sdo; sck_i = pol; #20;
      end
    end
    #20; ss_n = 1'b1; #20;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    reg_rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    reg_rd(2'd1, v); check("R1 status", v, 8'h00);
    check("R1 pins", {sck_o, sdo, irq, wake}, 4'b0000);
  endtask

  task automatic t_master_basic();
    logic [7:0] v;
    reg_wr(2'd0, 8'h03);
    mdl_start(8'h3C);
    reg_wr(2'd2, 8'hA5);
    wait_idle();
    mdl_on = 1'b0;
    check("R2 mosi byte", mdl_cap, 8'hA5);
    check("R2 edge count", mdl_edges, 16);
    check("R3 idle low", sck_o, 1'b0);
    reg_rd(2'd1, v); check("R2 full+done", v[3:0], 4'b0011);
    check("R12 irq off when disabled", irq, 1'b0);
    reg_wr(2'd0, 8'h13);
    check("R12 irq with ie", irq, 1'b1);
    reg_rd(2'd2, v); check("R2 rx byte", v, 8'h3C);
    reg_rd(2'd1, v); check("R8 full cleared", v[0], 1'b0);
    reg_wr(2'd1, 8'h02);
    reg_rd(2'd1, v); check("R12 done w1c", v[1], 1'b0);
    check("R12 irq cleared", irq, 1'b0);
  endtask

  task automatic t_master_sleep();
    logic [7:0] v;
    logic hs, hd;
    int he;
    reg_wr(2'd0, 8'h03);
    mdl_start(8'h81);
    reg_wr(2'd2, 8'h6E);
    repeat (9) @(negedge clk);
    sleep = 1'b1;
    @(negedge clk); hs = sck_o; hd = sdo; he = mdl_edges;
    repeat (40) @(negedge clk);
    check("R7 sck held", sck_o, hs);
    check("R7 sdo held", sdo, hd);
    check("R7 no edges in sleep", mdl_edges, he);
    check("R7 frozen mid-byte", (he > 0 && he < 16), 1'b1);
    @(negedge clk); addr = 2'd1; #1; check("R7 busy held", rdata[4], 1'b1);
    sleep = 1'b0;
    wait_idle();
    mdl_on = 1'b0;
    check("R7 total edges", mdl_edges, 16);
    check("R7 mosi byte", mdl_cap, 8'h6E);
    reg_rd(2'd2, v); check("R7 rx byte", v, 8'h81);
    reg_wr(2'd1, 8'h0E);
  endtask

  task automatic t_wcol();
    logic [7:0] v;
    reg_wr(2'd0, 8'h03);
    mdl_start(8'h42);
    reg_wr(2'd2, 8'h99);
    repeat (6) @(negedge clk);
    reg_wr(2'd2, 8'hFF);
    reg_rd(2'd1, v); check("R10 wcol set", v[3], 1'b1);
    wait_idle();
    mdl_on = 1'b0;
    check("R10 write ignored", mdl_cap, 8'h99);
    reg_rd(2'd2, v); check("R10 rx intact", v, 8'h42);
    reg_wr(2'd1, 8'h08);
    reg_rd(2'd1, v); check("R12 wcol w1c", v[3], 1'b0);
    reg_wr(2'd1, 8'h0E);
  endtask

  task automatic t_disable();
    logic [7:0] v;
    reg_wr(2'd0, 8'h07);
    reg_wr(2'd2, 8'h55);
    repeat (9) @(negedge clk);
    reg_rd(2'd1, v); check("R11 busy before", v[4], 1'b1);
    reg_wr(2'd0, 8'h06);
    check("R11 sck idle", sck_o, 1'b1);
    check("R11 sdo low", sdo, 1'b0);
    reg_rd(2'd1, v); check("R11 not busy", v[4], 1'b0);
    reg_wr(2'd0, 8'h07);
    repeat (40) @(negedge clk);
    check("R3 cpol idle high", sck_o, 1'b1);
    reg_rd(2'd1, v); check("R11 no completion", v[1:0], 2'b00);
  endtask

  task automatic t_slave_wake();
    logic [7:0] v, miso;
    reg_wr(2'd0, 8'h11);
    reg_wr(2'd2, 8'hC3);
    sleep = 1'b1;
    @(negedge clk); clk_run = 1'b0;
    #30;
    slave_xfer(8'h5A, 1'b0, 1'b0, miso);
    check("R5 wake w/o clock", wake, 1'b1);
    check("R3 miso mode0", miso, 8'hC3);
    clk_run = 1'b1; sleep = 1'b0;
    repeat (8) @(negedge clk);
    check("R5 wake released", wake, 1'b0);
    check("R12 irq on done", irq, 1'b1);
    reg_rd(2'd1, v); check("R4 full+done", v[1:0], 2'b11);
    reg_rd(2'd2, v); check("R4 rx byte", v, 8'h5A);
    reg_wr(2'd1, 8'h0E);
  endtask

  task automatic t_slave_nowake();
    logic [7:0] v, miso;
    reg_wr(2'd0, 8'h01);
    sleep = 1'b1;
    @(negedge clk); clk_run = 1'b0;
    #30;
    slave_xfer(8'h3D, 1'b0, 1'b0, miso);
    #40;
    check("R6 no wake", wake, 1'b0);
    clk_run = 1'b1; sleep = 1'b0;
    repeat (8) @(negedge clk);
    check("R6 wake stays low", wake, 1'b0);
    reg_rd(2'd1, v); check("R6 done set", v[1], 1'b1);
    check("R12 no irq", irq, 1'b0);
    reg_rd(2'd2, v); check("R6 rx byte", v, 8'h3D);
    reg_wr(2'd1, 8'h0E);
  endtask

  task automatic t_slave_modes_ovf();
    logic [7:0] v, miso;
    reg_wr(2'd0, 8'h0D);
    reg_wr(2'd2, 8'h96);
    slave_xfer(8'hE7, 1'b1, 1'b1, miso);
    repeat (8) @(negedge clk);
    check("R3 miso mode3", miso, 8'h96);
    reg_wr(2'd0, 8'h09);
    slave_xfer(8'h18, 1'b0, 1'b1, miso);
    repeat (8) @(negedge clk);
    check("R3 miso mode1", miso, 8'h96);
    reg_rd(2'd1, v); check("R9 overflow", v[2:0], 3'b111);
    reg_rd(2'd2, v); check("R9 old byte kept", v, 8'hE7);
    reg_wr(2'd1, 8'h04);
    reg_rd(2'd1, v); check("R12 ovf w1c", v[2], 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_master_basic();
    t_master_sleep();
    t_wcol();
    t_disable();
    t_slave_wake();
    t_slave_nowake();
    t_slave_modes_ovf();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule